// File: doc/BRIEF.md
# Tone Presence Guard-Time Validator

This block is the digital steering stage that sits behind a dual-tone frequency detector. The detector raises an early-steering input while it sees a valid tone pair and drives a 4-bit code for that pair. The validator accepts a code only after the early-steering input has stayed high for a programmable tone-present guard time. It then holds that digit until the input has stayed low for a separate tone-absent guard time. Only after that does it accept a new digit.

Short bursts are rejected without touching the output latch. Short dropouts inside an accepted tone are bridged. The two guard times are independent 16-bit tick counts, so either can be the longer one.

Once a code is latched, a fixed two-cycle settling delay follows. Then a delayed-steering flag rises, and a one-cycle strobe fires with it. A register block downstream can use that strobe to set its receive-full and interrupt flags. A guard-state output shows when a digit is held. An absence status bit shows when a valid pause has been seen.

Top module: `tone_guard_validator`

## Requirements
- R1: A code is registered only when `est_i` has been sampled high on `guard_present_i` consecutive rising edges (a value of 0 acts as 1). `code_o` takes the `code_i` value of the last of those edges, and `gt_o` rises on that same edge.
- R2: A high run on `est_i` shorter than the present guard time leaves `code_o`, `gt_o` and `dsteer_o` unchanged.
- R3: While a digit is held and `est_i` stays high, `gt_o` and `dsteer_o` stay high.
- R4: Absence is confirmed on the edge where `est_i` has been sampled low for `guard_absent_i` consecutive edges (0 acts as 1). On that edge `gt_o` and `dsteer_o` fall and `absent_o` rises.
- R5: A low run on `est_i` shorter than the absent guard time, inside a held digit, changes no output, and the absence count restarts from zero.
- R6: `code_o` changes only on a registration edge. After absence it keeps the last digit, whatever `code_i` does.
- R7: `dsteer_o` rises exactly SETTLE (2) edges after the registration edge. Absence confirmation is deferred until that settling has completed.
- R8: The present and absent guard times act independently: a short present time with a long absent time works, and so does the reverse.
- R9: `absent_o` clears on the registration edge and sets on the absence confirmation edge.
- R10: `new_o` is high for exactly one cycle, in the cycle `dsteer_o` rises, and once per registered digit.
- R11: After synchronous reset: `code_o`=0, `gt_o`=0, `dsteer_o`=0, `new_o`=0, `absent_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| est_i | input | 1 | Early steering, high while the detector sees a valid pair |
| code_i | input | 4 | Decoded tone-pair code from the detector |
| guard_present_i | input | 16 | Tone-present guard time in clock ticks |
| guard_absent_i | input | 16 | Tone-absent guard time in clock ticks |
| code_o | output | 4 | Latched code of the last registered digit |
| gt_o | output | 1 | Guard state: high while a digit is held |
| dsteer_o | output | 1 | Delayed steering flag |
| new_o | output | 1 | One-cycle strobe as `dsteer_o` rises |
| absent_o | output | 1 | Status bit, set by a confirmed pause, cleared by registration |

## Verification
A present counter that drifts by one shows directly at the ports. `gt_o` and `code_o` move one edge early or late, or a burst exactly one tick short of the guard time gets latched. These symptoms appear on the registration edge itself.

An absence counter that fails to restart after a dropout makes `gt_o` fall during a bridged gap. That shows within the absent guard time of the second gap.

A settle pipeline of the wrong depth moves the strobe and `dsteer_o` away from the edge two cycles after `gt_o` rises. The scoreboard catches this on the very first accepted digit.

// File: rtl/tgv_pkg.sv
package tgv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // no digit held, est low
    ST_QUAL = 2'd1,  // counting a present run
    ST_HELD = 2'd2,  // digit held, est high
    ST_DROP = 2'd3   // digit held, counting an absent run
  } tgv_state_e;
endpackage

// File: rtl/tgv_run_timer.sv
// Counts consecutive cycles of run_i; hit_o flags the cycle the run reaches
// the limit. Without take_i the count saturates at the hit point.
module tgv_run_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              take_i,
  input  logic [TIME_W-1:0] limit_i,
  output logic              hit_o
);
  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W-1:0] lim_m1;

  assign lim_m1 = (limit_i == '0) ? '0 : limit_i - 1'b1;
  assign hit_o  = run_i && (cnt_q >= lim_m1);

  always_ff @(posedge clk) begin
    if (rst || !run_i || take_i) begin
      cnt_q <= '0;
    end else if (!hit_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tgv_settle_pipe.sv
// Delays the registration pulse by DEPTH cycles; busy_o covers the flight.
module tgv_settle_pipe #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  output logic pulse_o,
  output logic busy_o
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign pulse_o = pulse_i;
      assign busy_o  = 1'b0;
    end else begin : g_pipe
      logic [DEPTH-1:0] sr_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sr_q <= '0;
        end else begin
          sr_q[0] <= pulse_i;
          for (int i = 1; i < DEPTH; i++) begin
            sr_q[i] <= sr_q[i-1];
          end
        end
      end
      assign pulse_o = sr_q[DEPTH-1];
      assign busy_o  = |sr_q;
    end
  endgenerate
endmodule

// File: rtl/tone_guard_validator.sv
module tone_guard_validator #(
  parameter int CODE_W = 4,
  parameter int TIME_W = 16,
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              est_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [TIME_W-1:0] guard_present_i,
  input  logic [TIME_W-1:0] guard_absent_i,
  output logic [CODE_W-1:0] code_o,
  output logic              gt_o,
  output logic              dsteer_o,
  output logic              new_o,
  output logic              absent_o
);
  import tgv_pkg::*;

  tgv_state_e state_q, state_d;
  logic pres_run, pres_hit;
  logic abs_run, abs_hit, abs_take;
  logic settle_out, settle_busy;
  logic do_register, do_confirm;
  logic held;

  assign held     = (state_q == ST_HELD) || (state_q == ST_DROP);
  assign pres_run = est_i && !held;
  assign abs_run  = !est_i && held;

  tgv_run_timer #(.TIME_W(TIME_W)) u_present (
    .clk(clk), .rst(rst), .run_i(pres_run), .take_i(pres_hit),
    .limit_i(guard_present_i), .hit_o(pres_hit)
  );

  assign do_register = pres_hit;
  assign do_confirm  = abs_hit && !settle_busy;
  assign abs_take    = do_confirm;

  tgv_run_timer #(.TIME_W(TIME_W)) u_absent (
    .clk(clk), .rst(rst), .run_i(abs_run), .take_i(abs_take),
    .limit_i(guard_absent_i), .hit_o(abs_hit)
  );

  tgv_settle_pipe #(.DEPTH(SETTLE)) u_settle (
    .clk(clk), .rst(rst), .pulse_i(do_register),
    .pulse_o(settle_out), .busy_o(settle_busy)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_QUAL: begin
        if (!est_i)           state_d = ST_IDLE;
        else if (do_register) state_d = ST_HELD;
        else                  state_d = ST_QUAL;
      end
      ST_HELD, ST_DROP: begin
        if (est_i)           state_d = ST_HELD;
        else if (do_confirm) state_d = ST_IDLE;
        else                 state_d = ST_DROP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      code_o   <= '0;
      gt_o     <= 1'b0;
      dsteer_o <= 1'b0;
      new_o    <= 1'b0;
      absent_o <= 1'b1;
    end else begin
      state_q <= state_d;
      new_o   <= settle_out;
      if (do_register) begin
        code_o   <= code_i;
        gt_o     <= 1'b1;
        absent_o <= 1'b0;
      end
      if (settle_out) begin
        dsteer_o <= 1'b1;
      end else if (do_confirm) begin
        dsteer_o <= 1'b0;
      end
      if (do_confirm) begin
        gt_o     <= 1'b0;
        absent_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tgv_checker.sv
module tgv_checker #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              est_i,
  input logic [CODE_W-1:0] code_o,
  input logic              gt_o,
  input logic              dsteer_o,
  input logic              new_o,
  input logic              absent_o
);
  AST_ACCEPT_NEEDS_TONE: assert property (@(posedge clk) disable iff (rst)
    $rose(gt_o) |-> $past(est_i)); // R1
  AST_LATCH_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !$stable(code_o) |-> $rose(gt_o)); // R6
  AST_HOLD_WHILE_TONE: assert property (@(posedge clk) disable iff (rst)
    (gt_o && est_i) |=> gt_o); // R3
  AST_RELEASE_NEEDS_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(gt_o) |-> !$past(est_i)); // R4
  AST_DSTEER_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
    $rose(dsteer_o) |-> (gt_o && $past(gt_o, 2) && $stable(code_o))); // R7
  AST_STROBE_WITH_DSTEER: assert property (@(posedge clk) disable iff (rst)
    new_o |-> $rose(dsteer_o)); // R10
  AST_ABSENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    absent_o |-> (!gt_o && !dsteer_o)); // R9
endmodule

bind tone_guard_validator tgv_checker #(.CODE_W(CODE_W)) u_tgv_checker (
  .clk(clk), .rst(rst), .est_i(est_i), .code_o(code_o), .gt_o(gt_o),
  .dsteer_o(dsteer_o), .new_o(new_o), .absent_o(absent_o)
);

// File: tb/tb_tone_guard_validator.sv
`timescale 1ns/1ps
module tb_tone_guard_validator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        est_i = 1'b0;
  logic [3:0]  code_i = '0;
  logic [15:0] guard_present_i = 16'd4;
  logic [15:0] guard_absent_i = 16'd3;
  logic [3:0]  code_o;
  logic        gt_o, dsteer_o, new_o, absent_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic prev_new = 1'b0;

  typedef struct {
    logic [3:0] code;
    int         due;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tone_guard_validator dut (
    .clk(clk), .rst(rst), .est_i(est_i), .code_i(code_i),
    .guard_present_i(guard_present_i), .guard_absent_i(guard_absent_i),
    .code_o(code_o), .gt_o(gt_o), .dsteer_o(dsteer_o), .new_o(new_o),
    .absent_o(absent_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one tone of hi ticks then lo ticks of silence; pushes the expected
  // strobe (code, cycle) when the run meets the present guard time (R1, R8).
  task automatic send_tone(input logic [3:0] c, input int hi, input int lo);
    int gp;
    exp_t e;
    gp = (guard_present_i == 0) ? 1 : int'(guard_present_i);
    if (hi >= gp) begin
      e.code = c;
      e.due  = cyc + gp + 2;
      sb_q.push_back(e);
    end
    est_i  = 1'b1;
    code_i = c;
    tick(hi);
    est_i  = 1'b0;
    code_i = ~c;
    tick(lo);
  endtask

  // Monitor: pops one expected digit per strobe (R7, R10).
  always @(negedge clk) begin
    if (!rst) begin
      if (new_o) begin
        if (prev_new) chk("R10 strobe longer than one cycle", 1, 0);
        if (sb_q.size() == 0) begin
          chk("R2 unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk("R10 strobe code", int'(code_o), int'(e.code));
          chk("R7 strobe cycle", cyc, e.due);
          chk("R10 dsteer with strobe", int'(dsteer_o), 1);
        end
      end
      prev_new = new_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    // R11 reset state
    chk("R11 code_o", int'(code_o), 0);
    chk("R11 gt_o", int'(gt_o), 0);
    chk("R11 dsteer_o", int'(dsteer_o), 0);
    chk("R11 new_o", int'(new_o), 0);
    chk("R11 absent_o", int'(absent_o), 1);
    rst = 1'b0;
    tick(2);

    // Directed timing: present guard 4, absent guard 3
    begin
      exp_t e;
      e.code = 4'd9;
      e.due  = cyc + 6;
      sb_q.push_back(e);
    end
    est_i = 1'b1; code_i = 4'd9;
    tick(3);
    chk("R1 no accept before guard", int'(gt_o), 0);
    tick(1);
    chk("R1 accept on guard edge", int'(gt_o), 1);
    chk("R1 code latched", int'(code_o), 9);
    chk("R9 absent cleared on accept", int'(absent_o), 0);
    chk("R7 dsteer not yet", int'(dsteer_o), 0);
    tick(1);
    chk("R7 dsteer still settling", int'(dsteer_o), 0);
    tick(1);
    chk("R7 dsteer after settle", int'(dsteer_o), 1);
    tick(3);
    chk("R3 hold while tone", int'(gt_o), 1);
    chk("R3 dsteer hold", int'(dsteer_o), 1);
    est_i = 1'b0;
    tick(2);
    chk("R5 dropout bridged gt", int'(gt_o), 1);
    chk("R5 dropout bridged dsteer", int'(dsteer_o), 1);
    est_i = 1'b1;
    tick(1);
    est_i = 1'b0; code_i = 4'd4;
    tick(2);
    chk("R5 count restarted", int'(gt_o), 1);
    chk("R5 absent still clear", int'(absent_o), 0);
    tick(1);
    chk("R4 gt falls on gap", int'(gt_o), 0);
    chk("R4 dsteer falls on gap", int'(dsteer_o), 0);
    chk("R9 absent set on gap", int'(absent_o), 1);
    chk("R6 code kept after gap", int'(code_o), 9);
    est_i = 1'b1; code_i = 4'd3;
    tick(3);
    est_i = 1'b0;
    chk("R2 short burst no accept", int'(gt_o), 0);
    chk("R2 short burst code kept", int'(code_o), 9);
    tick(1);
    chk("R2 still idle", int'(gt_o), 0);
    chk("R6 code kept after burst", int'(code_o), 9);
    tick(5);

    // Scoreboard runs, base guards
    for (int i = 0; i < 5; i++) begin
      send_tone(4'(i * 5 + 1), 4 + i, 7);
    end
    // R8: short present, long absent
    guard_present_i = 16'd2; guard_absent_i = 16'd10;
    send_tone(4'd12, 2, 14);
    send_tone(4'd7, 5, 14);
    send_tone(4'd2, 1, 14);
    // R8: long present, short absent; exact-length run exercises R7 deferral
    guard_present_i = 16'd12; guard_absent_i = 16'd1;
    send_tone(4'd15, 12, 5);
    send_tone(4'd6, 11, 5);
    send_tone(4'd0, 20, 5);
    // R1: zero guard acts as one tick
    guard_present_i = 16'd0; guard_absent_i = 16'd0;
    send_tone(4'd10, 1, 5);
    send_tone(4'd11, 3, 5);
    tick(5);
    chk("R10 all expected strobes seen", sb_q.size(), 0);
    chk("R6 final code", int'(code_o), 11);
    chk("R9 final absent", int'(absent_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule